// File: doc/BRIEF.md
# Configurable UART Character Receiver

This block turns an asynchronous serial line back into characters. A one-cycle strobe sixteen times per bit period paces it. It shares the line-format settings of its companion transmitter: the character length, whether a parity bit is present, the parity sense, and a stick mode in which the parity bit holds a fixed level. Each received character is placed on a byte-wide output, with the unused upper bits set to zero. A five-bit status word reports whether data is waiting and any error seen on that character.

Software or a surrounding controller reads the held character by pulsing a data-read strobe, which consumes it. It pulses a status-read strobe to acknowledge the error flags. The receiver holds a single character and has no queue. If a new character arrives before the last one is consumed, the new character is dropped and the loss is flagged.

Top module: `uart_char_rx`

## Requirements
- R1: The character length is 5, 6, 7 or 8 bits for length code 00, 01, 10 or 11. Bits arrive least significant first. `data_o` holds the character zero-extended to 8 bits.
- R2: A falling edge starts a frame only if the line is still low at the 8th tick after the edge was seen. A shorter low pulse produces no character and no status change.
- R3: When parity is enabled, the bit after the last data bit is checked. With even-select set, the data bits plus the parity bit must hold an even number of ones; with it clear, an odd number. A mismatch sets the parity-error flag (status bit 2). When parity is disabled, no parity bit is expected and the flag stays clear.
- R4: In stick mode with parity enabled, the parity bit must be 0 when even-select is set and 1 when it is clear. Any other value sets status bit 2.
- R5: Only the first stop bit is sampled. A new start bit may follow it immediately and is received.
- R6: A stop bit sampled low sets the framing-error flag (status bit 3).
- R7: When the data bits, the parity bit (if enabled) and the stop bit are all low, the break flag (status bit 4) is set together with the framing-error flag. The receiver then waits for the line to return high before it accepts another start bit.
- R8: A character that completes while data-ready is set is discarded, `data_o` keeps the earlier character, and the overrun flag (status bit 1) is set.
- R9: Status bit 0 is data-ready. A data-read strobe clears it. A status-read strobe clears bits 1 to 4. A flag set in the same cycle as a clear wins.
- R10: After reset, `data_o` and `stat_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial input, idle high |
| tick16_i | input | 1 | One-cycle strobe, 16 per bit period |
| wlen_i | input | 2 | Character length code (00=5 .. 11=8 bits) |
| par_en_i | input | 1 | Parity bit present and checked |
| par_even_i | input | 1 | Even parity when set, odd when clear |
| par_stick_i | input | 1 | Stick parity mode |
| rd_data_i | input | 1 | Data-read strobe, clears data-ready |
| rd_stat_i | input | 1 | Status-read strobe, clears error flags |
| data_o | output | 8 | Received character, zero-extended |
| stat_o | output | 5 | {break, framing, parity, overrun, data-ready} |

## Verification
Characters of every length are sent with bit patterns whose upper bits are set on the line. This exposes both a wrong bit count and missing zero-extension. Each parity mode receives one well-formed and one corrupted frame. The data values are chosen so that stick mode and ordinary even or odd checking disagree on the expected bit, which shows which rule the receiver applies. Low stop bits are sent with nonzero data, with all-zero data and with a high parity bit, which separates a plain framing error from a true break. Back-to-back frames, a short low glitch and a break held for several bit times probe the start detection, the overrun path and re-arming after a break.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned OSR_DEF = 16;
  localparam int unsigned DW_DEF  = 8;
  localparam int unsigned MIN_BITS = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
    logic ovr;
    logic rdy;
  } rx_stat_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR = OSR_DEF,
  parameter int unsigned DW  = DW_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  input  logic          tick_i,
  input  logic [1:0]    wlen_i,
  input  logic          par_en_i,
  input  logic          par_even_i,
  input  logic          par_stick_i,
  output logic          done_o,
  output logic [DW-1:0] char_o,
  output logic          perr_o,
  output logic          ferr_o,
  output logic          brk_o
);
  localparam int unsigned CW  = $clog2(OSR);
  localparam int unsigned IW  = $clog2(DW);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e      st_q;
  logic [CW-1:0]  cnt_q;
  logic [IW-1:0]  idx_q;
  logic [DW-1:0]  sh_q;
  logic           par_q, armed_q;
  logic           done_q, perr_q, ferr_q, brk_q;
  logic           sample, last_bit, par_bad;
  int unsigned    nbits;

  assign nbits    = MIN_BITS + int'(wlen_i);
  assign sample   = tick_i && (cnt_q == MID);
  assign last_bit = (int'(idx_q) == int'(nbits) - 1);
  // expected parity level is ~even in both modes; stick compares bit alone
  assign par_bad  = par_en_i &&
                    ((par_stick_i ? par_q : (^sh_q ^ par_q)) ^ ~par_even_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      armed_q <= 1'b1;
      done_q  <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i && st_q != ST_IDLE) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          if (rx_i) armed_q <= 1'b1;
          if (tick_i && armed_q && !rx_i) begin
            st_q  <= ST_START;
            cnt_q <= '0;
          end
        end
        ST_START: if (sample) begin
          if (rx_i) st_q <= ST_IDLE;
          else begin
            st_q  <= ST_DATA;
            idx_q <= '0;
            sh_q  <= '0;
            par_q <= 1'b0;
          end
        end
        ST_DATA: if (sample) begin
          sh_q[idx_q] <= rx_i;
          if (last_bit) st_q <= par_en_i ? ST_PAR : ST_STOP;
          else          idx_q <= idx_q + 1'b1;
        end
        ST_PAR: if (sample) begin
          par_q <= rx_i;
          st_q  <= ST_STOP;
        end
        ST_STOP: if (sample) begin
          done_q  <= 1'b1;
          perr_q  <= par_bad;
          ferr_q  <= !rx_i;
          brk_q   <= !rx_i && (sh_q == '0) && !(par_en_i && par_q);
          armed_q <= rx_i;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign char_o = sh_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;
  assign brk_o  = brk_q;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int unsigned DW = DW_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [DW-1:0] char_i,
  input  logic          perr_i,
  input  logic          ferr_i,
  input  logic          brk_i,
  input  logic          rd_data_i,
  input  logic          rd_stat_i,
  output logic [DW-1:0] data_o,
  output rx_stat_t      stat_o
);
  logic [DW-1:0] data_q;
  rx_stat_t      st_q;
  logic          accept;

  // holding slot frees up if it is being read this very cycle
  assign accept = done_i && (!st_q.rdy || rd_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      st_q   <= '0;
    end else begin
      if (rd_data_i) st_q.rdy <= 1'b0;
      if (rd_stat_i) begin
        st_q.ovr <= 1'b0;
        st_q.par <= 1'b0;
        st_q.frm <= 1'b0;
        st_q.brk <= 1'b0;
      end
      if (accept) begin
        data_q   <= char_i;
        st_q.rdy <= 1'b1;
        if (perr_i) st_q.par <= 1'b1;
        if (ferr_i) st_q.frm <= 1'b1;
        if (brk_i)  st_q.brk <= 1'b1;
      end else if (done_i) begin
        st_q.ovr <= 1'b1;
      end
    end
  end

  assign data_o = data_q;
  assign stat_o = st_q;
endmodule

// File: rtl/uart_char_rx.sv
module uart_char_rx
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR      = OSR_DEF,
  parameter int unsigned DW       = DW_DEF,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  input  logic          tick16_i,
  input  logic [1:0]    wlen_i,
  input  logic          par_en_i,
  input  logic          par_even_i,
  input  logic          par_stick_i,
  input  logic          rd_data_i,
  input  logic          rd_stat_i,
  output logic [DW-1:0] data_o,
  output logic [4:0]    stat_o
);
  logic          rx_s;
  logic          frame_done;
  logic [DW-1:0] frame_char;
  logic          frame_perr, frame_ferr, frame_brk;
  rx_stat_t      stat_s;

  uart_rx_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  uart_rx_frame #(.OSR(OSR), .DW(DW)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_i       (rx_s),
    .tick_i     (tick16_i),
    .wlen_i     (wlen_i),
    .par_en_i   (par_en_i),
    .par_even_i (par_even_i),
    .par_stick_i(par_stick_i),
    .done_o     (frame_done),
    .char_o     (frame_char),
    .perr_o     (frame_perr),
    .ferr_o     (frame_ferr),
    .brk_o      (frame_brk)
  );

  uart_rx_status #(.DW(DW)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (frame_done),
    .char_i   (frame_char),
    .perr_i   (frame_perr),
    .ferr_i   (frame_ferr),
    .brk_i    (frame_brk),
    .rd_data_i(rd_data_i),
    .rd_stat_i(rd_stat_i),
    .data_o   (data_o),
    .stat_o   (stat_s)
  );

  assign stat_o = stat_s;
endmodule

// File: rtl/uart_char_rx_chk.sv
module uart_char_rx_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_data_i,
  input logic          rd_stat_i,
  input logic          frame_done,
  input logic [DW-1:0] data_o,
  input logic [4:0]    stat_o
);
  // R9
  stat_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat_i && !frame_done |=> stat_o[4:1] == 4'b0);

  // R9
  rdy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_i && !frame_done |=> !stat_o[0]);

  // R8
  overrun_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && stat_o[0] && !rd_data_i |=> stat_o[1] && $stable(data_o));

  // R7
  break_has_frame_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[4] |-> stat_o[3]);

  // R9
  rdy_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[0]) |-> $past(frame_done));
endmodule

bind uart_char_rx uart_char_rx_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_data_i (rd_data_i),
  .rd_stat_i (rd_stat_i),
  .frame_done(frame_done),
  .data_o    (data_o),
  .stat_o    (stat_o)
);

// File: tb/uart_char_rx_bench.sv
module uart_char_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int BIT_CLKS   = 16 * TICK_DIV;
  localparam int NVEC       = 18;

  typedef struct packed {
    logic [1:0] wl;
    logic       pen, even, stick, pbit, stop;
    logic [7:0] din, dexp;
    logic [4:0] sexp;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 8'hA5, 5'h01}, // R1 8 bits
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3F, 8'h1F, 5'h01}, // R1 5 bits
    '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hEA, 8'h2A, 5'h01}, // R1 6 bits
    '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hD5, 8'h55, 5'h01}, // R1 7 bits
    '{2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA5, 8'hA5, 5'h01}, // R3 even ok
    '{2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA5, 8'hA5, 5'h05}, // R3 even bad
    '{2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA5, 8'hA5, 5'h01}, // R3 odd ok
    '{2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 8'hA5, 5'h05}, // R3 odd bad
    '{2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h07, 8'h07, 5'h01}, // R3 7 bits even
    '{2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h01, 8'h01, 5'h01}, // R4 stick 0 ok
    '{2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h01, 8'h01, 5'h05}, // R4 stick 0 bad
    '{2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h01, 8'h01, 5'h01}, // R4 stick 1 ok
    '{2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h01, 8'h01, 5'h05}, // R4 stick 1 bad
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81, 8'h81, 5'h09}, // R6
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 5'h19}, // R7
    '{2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 5'h19}, // R7 with parity
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 5'h01}, // R7 zeros, no break
    '{2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 5'h0D}  // R7 high parity, no break
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] wlen = 2'd3;
  logic       pen = 1'b0, peven = 1'b0, pstick = 1'b0;
  logic       rd_data = 1'b0, rd_stat = 1'b0;
  logic [7:0] data;
  logic [4:0] stat;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tick <= ~tick;

  uart_char_rx u_uart_char_rx (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .rx_i       (rx),
    .tick16_i   (tick),
    .wlen_i     (wlen),
    .par_en_i   (pen),
    .par_even_i (peven),
    .par_stick_i(pstick),
    .rd_data_i  (rd_data),
    .rd_stat_i  (rd_stat),
    .data_o     (data),
    .stat_o     (stat)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [1:0] wl, input logic [7:0] d,
                            input logic pe, input logic pb, input logic sb);
    send_bit(1'b0);
    for (int i = 0; i < 5 + int'(wl); i++) send_bit(d[i]);
    if (pe) send_bit(pb);
    send_bit(sb);
    rx = 1'b1;
  endtask

  task automatic read_all();
    rd_data = 1'b1; rd_stat = 1'b1;
    @(negedge clk);
    rd_data = 1'b0; rd_stat = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 data", data, 8'h00);
    check("R10 stat", {3'b0, stat}, 8'h00);
    repeat (BIT_CLKS) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      string tag;
      wlen = VECS[v].wl; pen = VECS[v].pen; peven = VECS[v].even; pstick = VECS[v].stick;
      send_frame(VECS[v].wl, VECS[v].din, VECS[v].pen, VECS[v].pbit, VECS[v].stop);
      send_bit(1'b1);
      if (VECS[v].pen && VECS[v].stick) tag = "R4";
      else if (VECS[v].pen)             tag = "R3";
      else if (!VECS[v].stop)           tag = (VECS[v].din == 8'h00) ? "R7" : "R6";
      else                              tag = "R1";
      check({tag, " data"}, data, VECS[v].dexp);
      check({tag, " stat"}, {3'b0, stat}, {3'b0, VECS[v].sexp});
      read_all();
      check("R9 cleared", {3'b0, stat}, 8'h00);
    end

    wlen = 2'd3; pen = 1'b0; peven = 1'b0; pstick = 1'b0;

    // R2: glitch shorter than half a bit
    rx = 1'b0;
    repeat (4 * TICK_DIV) @(negedge clk);
    rx = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    check("R2 glitch", {3'b0, stat}, 8'h00);

    // R5 / R8: second frame right after one stop bit, unread first frame
    send_frame(2'd3, 8'h11, 1'b0, 1'b0, 1'b1);
    send_frame(2'd3, 8'h22, 1'b0, 1'b0, 1'b1);
    send_bit(1'b1);
    check("R8 data kept", data, 8'h11);
    check("R5 R8 overrun", {3'b0, stat}, 8'h03);
    rd_stat = 1'b1; @(negedge clk); rd_stat = 1'b0; @(negedge clk);
    check("R9 stat read", {3'b0, stat}, 8'h01);
    rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; @(negedge clk);
    check("R9 data read", {3'b0, stat}, 8'h00);

    // R5: a frame right after the previous one is received once that one is read
    send_frame(2'd3, 8'h5A, 1'b0, 1'b0, 1'b1);
    send_bit(1'b1);
    check("R5 single", data, 8'h5A);
    read_all();

    // R7: long break, no second character until line returns high
    send_frame(2'd3, 8'h00, 1'b0, 1'b0, 1'b0);
    rx = 1'b0;
    repeat (3 * BIT_CLKS) @(negedge clk);
    rx = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    check("R7 long break", {3'b0, stat}, 8'h19);
    read_all();
    send_frame(2'd3, 8'hC3, 1'b0, 1'b0, 1'b1);
    send_bit(1'b1);
    check("R7 rearm data", data, 8'hC3);
    check("R7 rearm stat", {3'b0, stat}, 8'h01);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule